// File: doc/BRIEF.md
# Bus-Programmable Interval Timer with Routed Interrupt Pulse

This block is a small timer that a byte-wide processor bus programs through four consecutive byte locations. One location holds a control byte, and the other three hold a 24-bit interval. While the timer is enabled, an internal counter advances on every clock. When the count reaches the interval, the block emits a single-clock request pulse and the counter starts again from zero.

A routing bit in the control byte sends the pulse to one of two outputs. One output feeds the maskable interrupt input of the processor and the other feeds its non-maskable input. Any masking happens on the processor side. Software can reprogram the interval one byte at a time. The counter is cleared only when the timer goes from disabled to enabled, so writing the control byte again during a run does not disturb the period.

Top module: `ivtimer_top`

## Requirements
- R1: With `rst_n` low at a clock edge, the control byte, the interval and the counter all become zero. After reset every read returns 0x00 and neither request output pulses.
- R2: Reads are combinational from `bus_addr`. Offset 0 returns the enable flag in bit 0, the routing flag in bit 1 and zero in bits 7:2. Offsets 1, 2 and 3 return interval bits 7:0, 15:8 and 23:16.
- R3: A write to offset 1, 2 or 3 replaces only that interval byte. A write to offset 0 leaves the interval unchanged.
- R4: A control write with bit 0 = 1 while the timer is disabled clears the counter. With interval N, the first pulse is visible N clocks after the edge that captured the write.
- R5: A control write with bit 0 = 1 while the timer is already enabled does not clear the counter, and the pulse schedule continues unchanged.
- R6: While the timer is enabled and N is not zero, a request pulse is high for the single cycle after every N-th counting edge. With N = 1 the pulse repeats on every cycle.
- R7: Control bit 1 = 1 sends the pulse to `nmi_req`, and bit 1 = 0 sends it to `irq_req`. The two outputs are never high together.
- R8: An interval of zero never produces a pulse.
- R9: While the timer is disabled, the counter holds its value and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Byte offset within the block |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Maskable request pulse |
| nmi_req | output | 1 | Non-maskable request pulse |

## Verification
Read data is due in the same cycle as the address. The bench sets the address at a falling edge and samples `bus_rdata` a moment later. A write is captured at the rising edge that follows the falling edge where the bench drives it. Each counting edge after that adds one to the count, so with interval N the pulse is due at the N-th falling edge after the write. The bench counts falling edges from the write and checks both request lines at every one of them, so a pulse that arrives one cycle early or late, or appears on the wrong line, is reported.

// File: rtl/ivtimer_pkg.sv
// Shared constants for the interval timer: the offset of the control byte
// and the positions of its bits. Assumes the bus data width is one byte.
package ivtimer_pkg;
    localparam int BUS_W      = 8;
    localparam int CTRL_OFS   = 0;
    localparam int CTRL_EN_B  = 0;
    localparam int CTRL_RT_B  = 1;
    localparam int CTRL_BITS  = 2;
endpackage

// File: rtl/ivtimer_regs.sv
// Register file of the timer: the control byte (enable, route) and the
// interval, held as byte lanes. Produces the combinational read mux and a
// one-cycle start strobe when the enable bit goes from 0 to 1.
// Assumes the interval byte lanes sit at offsets 1..IVAL_BYTES.
module ivtimer_regs
    import ivtimer_pkg::*;
#(
    parameter int IVAL_BYTES = 3,
    parameter int ADDR_W     = 2,
    localparam int IVAL_W    = IVAL_BYTES * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              en_q,
    output logic              route_q,
    output logic              start,
    output logic [IVAL_W-1:0] ival_q
);
    logic ctrl_wr;

    // Decode a write to the control byte and detect the off-to-on edge.
    always_comb begin
        ctrl_wr = bus_wr && (int'(bus_addr) == CTRL_OFS);
        start   = ctrl_wr && bus_wdata[CTRL_EN_B] && !en_q;
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            route_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q    <= bus_wdata[CTRL_EN_B];
            route_q <= bus_wdata[CTRL_RT_B];
        end
    end

    // One storage lane per interval byte.
    for (genvar g = 0; g < IVAL_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                ival_q[g*BUS_W +: BUS_W] <= '0;
            else if (bus_wr && int'(bus_addr) == g + 1)
                ival_q[g*BUS_W +: BUS_W] <= bus_wdata;
        end

        // R3: a write elsewhere leaves this lane unchanged.
        p_lane_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && int'(bus_addr) != g + 1) |=> $stable(ival_q[g*BUS_W +: BUS_W]));
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == CTRL_OFS) begin
            bus_rdata[CTRL_EN_B] = en_q;
            bus_rdata[CTRL_RT_B] = route_q;
        end else begin
            for (int i = 0; i < IVAL_BYTES; i++)
                if (int'(bus_addr) == i + 1)
                    bus_rdata = ival_q[i*BUS_W +: BUS_W];
        end
    end
endmodule

// File: rtl/ivtimer_count.sv
// Period counter: clears on the start strobe, counts while enabled, and
// flags a hit when the next count equals a non-zero interval, then wraps
// to zero. Assumes start is only raised while en is low.
module ivtimer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [CNT_W-1:0] ival,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next count and terminal-count compare.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        hit     = en && (ival != '0) && (cnt_inc == ival);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (en)
            cnt_q <= hit ? '0 : cnt_inc;
    end

    // R4: the first cycle after an enable turn-on starts from zero.
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en)) |-> (cnt_q == '0));

    // R9: the count is frozen while the timer stays disabled.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> $stable(cnt_q));

    // R6: a hit always wraps the counter to zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0));
endmodule

// File: rtl/ivtimer_route.sv
// Request router: registers the hit into a one-cycle pulse on the line that
// the route flag selects at the moment of the hit.
module ivtimer_route (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic route_nmi,
    output logic irq_q,
    output logic nmi_q
);
    // Pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            nmi_q <= 1'b0;
        end else begin
            irq_q <= hit && !route_nmi;
            nmi_q <= hit && route_nmi;
        end
    end

    // R7: the pulse lands on exactly the selected line.
    p_line_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |-> (nmi_q == $past(route_nmi)) && (irq_q == !$past(route_nmi)));

    // R7: never both lines at once.
    p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_q, nmi_q}) <= 1);
endmodule

// File: rtl/ivtimer_top.sv
// Interval timer top: byte-bus register file, period counter and request
// router. Assumes a single clock domain and a synchronous active-low reset.
module ivtimer_top
    import ivtimer_pkg::*;
#(
    parameter int IVAL_BYTES = 3,
    localparam int IVAL_W    = IVAL_BYTES * BUS_W,
    localparam int ADDR_W    = $clog2(IVAL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_req,
    output logic              nmi_req
);
    logic              en_w;
    logic              route_w;
    logic              start_w;
    logic              hit_w;
    logic [IVAL_W-1:0] ival_w;

    ivtimer_regs #(.IVAL_BYTES(IVAL_BYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_q      (en_w),
        .route_q   (route_w),
        .start     (start_w),
        .ival_q    (ival_w)
    );

    ivtimer_count #(.CNT_W(IVAL_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_w),
        .start (start_w),
        .ival  (ival_w),
        .hit   (hit_w)
    );

    ivtimer_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit_w),
        .route_nmi (route_w),
        .irq_q     (irq_req),
        .nmi_q     (nmi_req)
    );

    // R8: a pulse only follows a cycle with a non-zero interval.
    p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || nmi_req) |-> ($past(ival_w) != '0));

    // R9: no pulse follows a cycle in which the timer was disabled.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_w) |-> !(irq_req || nmi_req));
endmodule

// File: tb/sim_ivtimer_top.sv
module sim_ivtimer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req, nmi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ivtimer_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    // Vector: {route_nmi, interval[23:0]}
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 24'd3}, {1'b1, 24'd5}, {1'b0, 24'd1},
        {1'b1, 24'd8}, {1'b1, 24'd2}, {1'b0, 24'h000102}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the write is captured at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic lines(input string tag, input logic ei, input logic en);
        chk(tag, {irq_req, nmi_req}, {ei, en});
    endtask

    task automatic set_ival(input logic [23:0] v);
        wr(2'd1, v[7:0]); wr(2'd2, v[15:8]); wr(2'd3, v[23:16]);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd("R1 ctrl", 2'd0, 8'h00);
        rd("R1 ival0", 2'd1, 8'h00);
        rd("R1 ival1", 2'd2, 8'h00);
        rd("R1 ival2", 2'd3, 8'h00);
        lines("R1 lines", 0, 0);

        // Table walk: R6 period, R7 routing, R2 readback
        for (int v = 0; v < NV; v++) begin
            logic rt;
            int   n;
            rt = VEC[v][24];
            n  = int'(VEC[v][23:0]);
            wr(2'd0, 8'h00);
            set_ival(VEC[v][23:0]);
            rd("R2 ival lo", 2'd1, VEC[v][7:0]);
            rd("R2 ival mid", 2'd2, VEC[v][15:8]);
            wr(2'd0, {6'b0, rt, 1'b1});
            rd("R2 ctrl", 2'd0, {6'b0, rt, 1'b1});
            for (int k = 1; k <= 2 * n; k++) begin
                logic p;
                @(negedge clk);
                p = (k % n) == 0;
                lines("R6 R7 period/route", p && !rt, p && rt);
            end
        end
        wr(2'd0, 8'h00);

        // R2: unused control bits read zero
        wr(2'd0, 8'hFF);
        rd("R2 ctrl unused", 2'd0, 8'h03);
        wr(2'd0, 8'h00);

        // R3: single byte lane replacement; control write keeps interval
        set_ival(24'h332211);
        wr(2'd2, 8'hAB);
        wr(2'd0, 8'h02);
        rd("R3 lane0", 2'd1, 8'h11);
        rd("R3 lane1", 2'd2, 8'hAB);
        rd("R3 lane2", 2'd3, 8'h33);
        wr(2'd0, 8'h00);

        // R5: re-enable while running does not restart
        set_ival(24'd6);
        wr(2'd0, 8'h01);
        for (int k = 1; k <= 3; k++) begin @(negedge clk); lines("R5 pre", 0, 0); end
        wr(2'd0, 8'h01);               // counter now 4
        @(negedge clk); lines("R5 no pulse yet", 0, 0);
        @(negedge clk); lines("R5 pulse on schedule", 1, 0);
        wr(2'd0, 8'h00);

        // R4 / R9: disable holds, off-to-on restarts
        set_ival(24'd4);
        wr(2'd0, 8'h01);
        @(negedge clk); @(negedge clk);
        wr(2'd0, 8'h00);               // counter stopped at 3
        for (int k = 1; k <= 6; k++) begin @(negedge clk); lines("R9 disabled quiet", 0, 0); end
        wr(2'd0, 8'h01);
        for (int k = 1; k <= 3; k++) begin @(negedge clk); lines("R4 restart no early", 0, 0); end
        @(negedge clk); lines("R4 restart pulse", 1, 0);
        wr(2'd0, 8'h00);

        // R8: zero interval never fires
        set_ival(24'd0);
        wr(2'd0, 8'h01);
        for (int k = 1; k <= 40; k++) begin @(negedge clk); lines("R8 zero quiet", 0, 0); end
        wr(2'd0, 8'h03);
        for (int k = 1; k <= 10; k++) begin @(negedge clk); lines("R8 zero quiet nmi", 0, 0); end

        // R1: reset mid-run clears everything
        set_ival(24'd5);
        wr(2'd0, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        rd("R1 mid ctrl", 2'd0, 8'h00);
        rd("R1 mid ival", 2'd1, 8'h00);
        for (int k = 1; k <= 10; k++) begin @(negedge clk); lines("R1 mid quiet", 0, 0); end

        done = 1;
        summary();
        $finish;
    end
endmodule